// File: doc/BRIEF.md
# Thermal Threshold Interrupt Unit

This unit watches a stream of filtered temperature samples, each a 12-bit code tagged with a sensor index and a valid flag. Only samples from sensor 0 are evaluated. Each such sample is compared against five programmable limits:

- a hot limit;
- a normal-to-hot limit;
- a cold limit;
- an upper offset limit;
- a lower offset limit.

A comparison that trips sets a sticky status bit. The status bits are gated by an enable mask and OR-ed together into one level-sensitive interrupt line.

Software programs the limits and the enable mask through a small register port. In the interrupt handler it reads the status register and writes the read value back, which clears every pending bit.

The hot check uses the larger of the hot limit and the effective normal-to-hot limit. When the hot check trips, the hot bit and the normal-to-hot bit are set together. A normal-to-hot limit of zero is treated as unprogrammed, and the cold limit then takes its place.

Top module: `thermal_trip_irq`

## Requirements
- R1: The register port reaches the following registers:
  - address 0: hot limit;
  - address 1: normal-to-hot limit;
  - address 2: cold limit;
  - address 3: upper offset limit;
  - address 4: lower offset limit;
  - address 5: 5-bit enable mask, whose upper read bits are zero;
  - address 6: 5-bit status.

  The limits are 12 bits wide. A write takes effect at the next clock edge, and reads are combinational.
- R2: The status and enable bit positions are:
  - bit 0: hot;
  - bit 1: cold;
  - bit 2: upper offset;
  - bit 3: lower offset;
  - bit 4: normal-to-hot.
- R3: A sample strictly below the cold limit sets bit 1.
- R4: A sample strictly above the larger of the hot limit and the effective normal-to-hot limit sets bit 0 and bit 4 in the same cycle.
- R5: When the normal-to-hot limit reads zero, the cold limit is used as the effective normal-to-hot limit.
- R6: A sample strictly above the upper offset limit sets bit 2. A sample strictly below the lower offset limit sets bit 3.
- R7: Status changes only on a sample whose valid flag is 1 and whose sensor index is 0. Any other sample leaves status untouched.
- R8: A status bit stays set until a status write carries a 1 in its position. Zero bits in that write have no effect, so writing back the value read clears all pending bits.
- R9: If a bit is set by a sample in the same cycle as it is cleared by a write, the bit ends up set.
- R10: The interrupt output equals the OR of (status AND enable), registered so that it follows a status or enable change by one clock.
- R11: After reset, all limits, the enable mask, the status and the interrupt are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Sample qualifier |
| sampleSensor | input | SENSOR_W | Sensor index of the sample |
| sampleValue | input | TEMP_W | Filtered temperature code |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address for read and write |
| regWrData | input | TEMP_W | Register write data |
| regRdData | output | TEMP_W | Combinational read data |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the unit with its default parameters: a 12-bit sample, a 2-bit sensor index and a 3-bit address. At that width every one of the 4096 sample codes can be driven exhaustively, under three limit sets.

- The first set has the hot limit dominant.
- The second has the normal-to-hot limit dominant.
- The third leaves the normal-to-hot limit at zero, so the cold limit takes over its role. This set also places the offset limits at the extremes of the range, where they can never trip.

Directed sequences then cover the remaining behaviours: non-zero sensor indices and unqualified samples, partial and write-back clears, a clear colliding with a set, and the one-cycle interrupt latency.

// File: rtl/thermal_trip_pkg.sv
`timescale 1ns/1ps
package thermal_trip_pkg;
  // status / enable bit positions
  localparam int ST_W     = 5;
  localparam int BIT_HOT  = 0;
  localparam int BIT_COLD = 1;
  localparam int BIT_HOFS = 2;
  localparam int BIT_LOFS = 3;
  localparam int BIT_N2H  = 4;

  // limit register slots, equal to their addresses
  localparam int NUM_THR  = 5;
  localparam int THR_HOT  = 0;
  localparam int THR_N2H  = 1;
  localparam int THR_COLD = 2;
  localparam int THR_HOFS = 3;
  localparam int THR_LOFS = 4;
  localparam int ADDR_EN  = 5;
  localparam int ADDR_STS = 6;

  typedef struct packed {
    logic [NUM_THR-1:0] thrWr;
    logic               enWr;
    logic               stsWr;
    logic               sampleTake;
  } strobe_t;
endpackage

// File: rtl/thermal_trip_ctrl.sv
`timescale 1ns/1ps
module thermal_trip_ctrl
  import thermal_trip_pkg::*;
#(
  parameter int SENSOR_W = 2,
  parameter int ADDR_W   = 3
) (
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                sampleValid,
  input  logic [SENSOR_W-1:0] sampleSensor,
  output strobe_t             strobes
);
  logic [NUM_THR-1:0] thrSel;
  logic               enSel;
  logic               stsSel;
  logic               take;

  for (genvar i = 0; i < NUM_THR; i++) begin : g_thrSel
    assign thrSel[i] = regWrEn && (regAddr == ADDR_W'(i));
  end

  assign enSel  = regWrEn && (regAddr == ADDR_W'(ADDR_EN));
  assign stsSel = regWrEn && (regAddr == ADDR_W'(ADDR_STS));
  assign take   = sampleValid && (sampleSensor == '0);

  always_comb begin
    strobes.thrWr      = thrSel;
    strobes.enWr       = enSel;
    strobes.stsWr      = stsSel;
    strobes.sampleTake = take;
    AST_ONE_TARGET: assert ($onehot0({thrSel, enSel, stsSel})); // R1
  end
endmodule

// File: rtl/thermal_trip_dp.sv
`timescale 1ns/1ps
module thermal_trip_dp
  import thermal_trip_pkg::*;
#(
  parameter int TEMP_W = 12,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [TEMP_W-1:0] wrData,
  input  logic [TEMP_W-1:0] sampleValue,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [TEMP_W-1:0] rdData,
  output logic              irq
);
  logic [TEMP_W-1:0] thrQ [NUM_THR];
  logic [ST_W-1:0]   enQ;
  logic [ST_W-1:0]   stsQ;
  logic              irqQ;
  logic [TEMP_W-1:0] n2hEff;
  logic [TEMP_W-1:0] hotEff;
  logic [ST_W-1:0]   setVec;
  logic [ST_W-1:0]   clrVec;

  // limit and enable registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_THR; i++) thrQ[i] <= '0;
      enQ <= '0;
    end else begin
      for (int i = 0; i < NUM_THR; i++)
        if (strobes.thrWr[i]) thrQ[i] <= wrData;
      if (strobes.enWr) enQ <= wrData[ST_W-1:0];
    end
  end

  // comparison: a zero normal-to-hot limit defers to the cold limit
  always_comb begin
    n2hEff = (thrQ[THR_N2H] != '0) ? thrQ[THR_N2H] : thrQ[THR_COLD];
    hotEff = (thrQ[THR_HOT] > n2hEff) ? thrQ[THR_HOT] : n2hEff;
    setVec = '0;
    if (strobes.sampleTake) begin
      setVec[BIT_HOT]  = sampleValue > hotEff;
      setVec[BIT_N2H]  = sampleValue > hotEff;
      setVec[BIT_COLD] = sampleValue < thrQ[THR_COLD];
      setVec[BIT_HOFS] = sampleValue > thrQ[THR_HOFS];
      setVec[BIT_LOFS] = sampleValue < thrQ[THR_LOFS];
    end
    clrVec = strobes.stsWr ? wrData[ST_W-1:0] : '0;
  end

  // sticky status (set beats clear) and registered interrupt
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stsQ <= '0;
      irqQ <= 1'b0;
    end else begin
      stsQ <= (stsQ & ~clrVec) | setVec;
      irqQ <= |(stsQ & enQ);
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_THR; i++)
      if (rdAddr == ADDR_W'(i)) rdData = thrQ[i];
    if (rdAddr == ADDR_W'(ADDR_EN))  rdData = TEMP_W'(enQ);
    if (rdAddr == ADDR_W'(ADDR_STS)) rdData = TEMP_W'(stsQ);
  end

  assign irq = irqQ;

  AST_COLD_SET: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.sampleTake && (sampleValue < thrQ[THR_COLD])) |=> stsQ[BIT_COLD]); // R3

  AST_HOT_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stsQ[BIT_HOT]) |-> stsQ[BIT_N2H]); // R4

  AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.sampleTake |=> ((stsQ & ~$past(stsQ)) == '0)); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.sampleTake && strobes.stsWr && (sampleValue < thrQ[THR_LOFS]))
      |=> stsQ[BIT_LOFS]); // R9

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rstN)
    irqQ == $past(|(stsQ & enQ))); // R10

  for (genvar b = 0; b < ST_W; b++) begin : g_sticky
    AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (stsQ[b] && !(strobes.stsWr && wrData[b])) |=> stsQ[b]); // R8
  end
endmodule

// File: rtl/thermal_trip_irq.sv
`timescale 1ns/1ps
module thermal_trip_irq
  import thermal_trip_pkg::*;
#(
  parameter int TEMP_W   = 12,
  parameter int SENSOR_W = 2,
  parameter int ADDR_W   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SENSOR_W-1:0] sampleSensor,
  input  logic [TEMP_W-1:0]   sampleValue,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [TEMP_W-1:0]   regWrData,
  output logic [TEMP_W-1:0]   regRdData,
  output logic                irq
);
  strobe_t strobes;

  thermal_trip_ctrl #(.SENSOR_W(SENSOR_W), .ADDR_W(ADDR_W)) uCtrl (
    .regWrEn      (regWrEn),
    .regAddr      (regAddr),
    .sampleValid  (sampleValid),
    .sampleSensor (sampleSensor),
    .strobes      (strobes)
  );

  thermal_trip_dp #(.TEMP_W(TEMP_W), .ADDR_W(ADDR_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrData      (regWrData),
    .sampleValue (sampleValue),
    .rdAddr      (regAddr),
    .rdData      (regRdData),
    .irq         (irq)
  );
endmodule

// File: tb/thermal_trip_irq_test.sv
`timescale 1ns/1ps
module thermal_trip_irq_test;
  localparam int TW = 12;
  localparam int SW = 2;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sampleValid = 1'b0;
  logic [SW-1:0] sampleSensor = '0;
  logic [TW-1:0] sampleValue = '0;
  logic          regWrEn = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [TW-1:0] regWrData = '0;
  logic [TW-1:0] regRdData;
  logic          irq;

  int nChk = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  thermal_trip_irq #(.TEMP_W(TW), .SENSOR_W(SW), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleSensor(sampleSensor),
    .sampleValue(sampleValue), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input int a, input int d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = AW'(a); regWrData = TW'(d);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input int a, output int r);
    regAddr = AW'(a);
    #1 r = int'(regRdData);
  endtask

  task automatic sample(input int v, input int sensor, input logic vld);
    @(negedge clk);
    sampleValid = vld; sampleSensor = SW'(sensor); sampleValue = TW'(v);
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic sampleAndClear(input int v, input int clr);
    @(negedge clk);
    sampleValid = 1'b1; sampleSensor = '0; sampleValue = TW'(v);
    regWrEn = 1'b1; regAddr = AW'(6); regWrData = TW'(clr);
    @(negedge clk);
    sampleValid = 1'b0; regWrEn = 1'b0;
  endtask

  task automatic loadLimits(input int h, input int n, input int c, input int hi, input int lo);
    wrReg(0, h); wrReg(1, n); wrReg(2, c); wrReg(3, hi); wrReg(4, lo);
  endtask

  // bit0 hot, bit1 cold, bit2 upper offset, bit3 lower offset, bit4 normal-to-hot
  function automatic int expSts(int v, int h, int n, int c, int hi, int lo);
    int eff = (n != 0) ? n : c;
    int he = (h > eff) ? h : eff;
    int e = 0;
    if (v > he) e |= 32'h11;
    if (v < c)  e |= 32'h02;
    if (v > hi) e |= 32'h04;
    if (v < lo) e |= 32'h08;
    return e;
  endfunction

  task automatic sweep(input string req, input int h, input int n, input int c,
                       input int hi, input int lo);
    int r;
    loadLimits(h, n, c, hi, lo);
    wrReg(6, 'hFFF);
    for (int v = 0; v < (1 << TW); v++) begin
      sample(v, 0, 1'b1);
      rdReg(6, r);
      chk(req, r, expSts(v, h, n, c, hi, lo));
      wrReg(6, 'hFFF);
    end
  endtask

  initial begin
    #(4 * 190000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChk - nFail, nChk + 1);
    $finish;
  end

  initial begin
    int r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11 reset state
    for (int a = 0; a < 7; a++) begin
      rdReg(a, r);
      chk("R11 reset register", r, 0);
    end
    chk("R11 reset irq", int'(irq), 0);

    // R1 readback
    loadLimits(3000, 2500, 500, 2000, 1000);
    rdReg(0, r); chk("R1 hot limit", r, 3000);
    rdReg(1, r); chk("R1 n2h limit", r, 2500);
    rdReg(2, r); chk("R1 cold limit", r, 500);
    rdReg(3, r); chk("R1 upper offset", r, 2000);
    rdReg(4, r); chk("R1 lower offset", r, 1000);
    wrReg(5, 'hFFF); rdReg(5, r); chk("R1 enable width", r, 'h1F);
    wrReg(5, 0);

    // exhaustive sweeps: R2 R3 R4 R5 R6
    sweep("R2 R3 R4 R6 hot dominant", 3000, 2500, 500, 2000, 1000);
    sweep("R3 R4 R6 n2h dominant", 1000, 2000, 300, 3500, 100);
    sweep("R5 R4 zero n2h uses cold", 1500, 0, 2200, 4095, 0);

    loadLimits(3000, 2500, 500, 2000, 1000);
    wrReg(6, 'hFFF);
    // R7 filtering
    sample(4095, 1, 1'b1); rdReg(6, r); chk("R7 sensor 1 ignored", r, 0);
    sample(4095, 3, 1'b1); rdReg(6, r); chk("R7 sensor 3 ignored", r, 0);
    sample(4095, 0, 1'b0); rdReg(6, r); chk("R7 invalid ignored", r, 0);

    // R8 sticky and write-one-to-clear
    sample(4095, 0, 1'b1); rdReg(6, r); chk("R8 set hot/n2h/upper", r, 'h15);
    sample(1500, 0, 1'b1); rdReg(6, r); chk("R8 sticky", r, 'h15);
    wrReg(6, 'h01); rdReg(6, r); chk("R8 partial clear", r, 'h14);
    wrReg(6, 'h00); rdReg(6, r); chk("R8 zero write no effect", r, 'h14);
    wrReg(6, r); rdReg(6, r); chk("R8 write back clears", r, 0);

    // R9 set beats clear
    sample(100, 0, 1'b1); rdReg(6, r); chk("R9 setup", r, 'h0A);
    sampleAndClear(100, 'hFFF); rdReg(6, r); chk("R9 set wins", r, 'h0A);
    sampleAndClear(1500, 'h0A); rdReg(6, r); chk("R9 clear without set", r, 0);

    // R10 interrupt
    wrReg(5, 'h04);
    sample(2500, 0, 1'b1);
    chk("R10 irq latency", int'(irq), 0);
    @(negedge clk); chk("R10 irq asserted", int'(irq), 1);
    wrReg(5, 'h01);
    @(negedge clk); chk("R10 irq masked", int'(irq), 0);
    wrReg(5, 'h04);
    @(negedge clk); chk("R10 irq re-enabled", int'(irq), 1);
    wrReg(6, 'h04);
    @(negedge clk); chk("R10 irq after clear", int'(irq), 0);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule